// File: doc/BRIEF.md
# Two-Byte Register Mini Processor

A small multicycle processor with four 8-bit general registers, an 8-bit program counter and one 256-byte memory. Code and data share the memory, and it is reached through a single internal port. Every instruction is two bytes long. The first byte holds a 4-bit operation code in its upper half and a destination or source register number in its lower half. The second byte is a direct address, an immediate value, or a second register number held in its upper half.

The processor spends three cycles on every instruction: it reads the first byte, reads the second byte, then executes. The instruction set covers the following:

- a direct load and a direct store;
- a store through a register pointer;
- an immediate move;
- register add and register subtract, both wrapping modulo 256;
- one branch, which moves the program counter by a signed offset when a named register is zero.

An unconditional jump therefore tests a register that holds zero. An undefined operation code, or a register number above the implemented range, stops the processor and raises `halted`.

A test port loads the memory while the processor is stopped and reads any byte back at all times. A one-cycle `start` pulse clears the program counter to zero and begins fetching. Registers keep their values across runs and are cleared only by reset.

Top module: `twobyte_cpu`

## Requirements
- R1: After reset `busy` and `halted` are 0. A `start` pulse seen while idle or halted sets the program counter to 0 and raises `busy` from the next cycle; a `start` pulse while running has no effect.
- R2: The operation code is bits 7:4 of byte one and Rn is bits 3:0 of byte one. For codes 0010, 0100 and 0101, Rm is bits 7:4 of byte two and bits 3:0 of byte two are ignored.
- R3: Code 0011 sets Rn to byte two. Code 0000 sets Rn to the memory byte at the address in byte two. Code 0001 writes Rn to the memory byte at the address in byte two.
- R4: Code 0010 writes Rm to the memory byte whose address is the value of Rn.
- R5: Code 0100 sets Rn to Rn+Rm and code 0101 sets Rn to Rn-Rm, both modulo 256.
- R6: Code 1000 with Rn equal to 0 sets the program counter to the address of the next instruction plus byte two read as a two's-complement number. With Rn nonzero, execution continues at the next instruction.
- R7: The following stop the processor in its execute cycle: any code other than the seven above, an Rn number of 4 or more, or an Rm number of 4 or more for codes 0010/0100/0101. The offending instruction changes no register and no memory byte, `halted` becomes 1, `busy` becomes 0, and no further byte is fetched.
- R8: Every instruction, the stopping one included, takes exactly three cycles. A program of N legal instructions followed by a stopping instruction raises `halted` 3*(N+1) cycles after the start edge.
- R9: A test-port write is stored only while `busy` is 0 and is ignored while `busy` is 1. `tstRdata` always shows the memory byte at `tstAddr`.
- R10: A loop that sums 10 down to 1, with a zero register used to branch back unconditionally, leaves 55 in the total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin execution at address 0 |
| busy | output | 1 | Processor is fetching or executing |
| halted | output | 1 | Processor stopped on an illegal instruction |
| tstWe | input | 1 | Test-port write strobe |
| tstAddr | input | 8 | Test-port byte address |
| tstWdata | input | 8 | Test-port write data |
| tstRdata | output | 8 | Memory byte at `tstAddr` |

## Verification
A test-port write and a processor memory access can land in the same cycle, because the test port stays live while a program runs. The bench provokes this by writing a marker byte through the test port in the middle of the summing loop. It then judges the result in two ways: the marker address must still hold its earlier value after the stop, and the loop must still store 55. Randomly chosen add and subtract trials, with distinct registers and operands that wrap, are mixed with directed programs for loads, pointer stores, taken and untaken branches, illegal codes and out-of-range registers.

// File: rtl/twobyte_cpu_pkg.sv
package twobyte_cpu_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH1, ST_FETCH2, ST_EXEC, ST_HALT
  } state_e;

  typedef enum logic [1:0] {ADDR_PC, ADDR_IMM, ADDR_RN} addrSel_e;
  typedef enum logic [1:0] {WSRC_MEM, WSRC_IMM, WSRC_ADD, WSRC_SUB} wsrc_e;

  typedef struct packed {
    logic     loadIr1;
    logic     loadIr2;
    logic     pcInc;
    logic     pcZero;
    logic     pcBranch;
    logic     regWe;
    wsrc_e    regSrc;
    logic     memWe;
    addrSel_e addrSel;
    logic     wdataRm;
  } strobes_t;

  localparam logic [NIB_W-1:0] OP_LDD = 4'b0000;
  localparam logic [NIB_W-1:0] OP_STD = 4'b0001;
  localparam logic [NIB_W-1:0] OP_STI = 4'b0010;
  localparam logic [NIB_W-1:0] OP_LDI = 4'b0011;
  localparam logic [NIB_W-1:0] OP_ADD = 4'b0100;
  localparam logic [NIB_W-1:0] OP_SUB = 4'b0101;
  localparam logic [NIB_W-1:0] OP_JZ  = 4'b1000;
endpackage

// File: rtl/twobyte_cpu_mem.sv
module twobyte_cpu_mem
  import twobyte_cpu_pkg::*;
#(
  parameter int DEPTH = 2 ** BYTE_W
) (
  input  logic              clk,
  input  logic              busy,
  input  logic              we,
  input  logic [BYTE_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              tstWe,
  input  logic [BYTE_W-1:0] tstAddr,
  input  logic [BYTE_W-1:0] tstWdata,
  output logic [BYTE_W-1:0] tstRdata
);
  logic [BYTE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      cells[addr] <= wdata;
    else if (tstWe && !busy)
      cells[tstAddr] <= tstWdata;
  end

  assign rdata    = cells[addr];
  assign tstRdata = cells[tstAddr];
endmodule

// File: rtl/twobyte_cpu_dp.sv
module twobyte_cpu_dp
  import twobyte_cpu_pkg::*;
#(
  parameter int NUM_REGS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          ctl,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [BYTE_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata,
  output logic [BYTE_W-1:0] ir1,
  output logic [BYTE_W-1:0] ir2,
  output logic              rnZero
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [BYTE_W-1:0] regs [NUM_REGS];
  logic [BYTE_W-1:0] pc;
  logic [BYTE_W-1:0] rnVal, rmVal, regNext;
  logic [IDX_W-1:0]  rnIdx, rmIdx;

  assign rnIdx = ir1[IDX_W-1:0];
  assign rmIdx = ir2[BYTE_W-NIB_W +: IDX_W];
  assign rnVal = regs[rnIdx];
  assign rmVal = regs[rmIdx];
  assign rnZero = (rnVal == '0);

  always_comb begin
    unique case (ctl.regSrc)
      WSRC_MEM: regNext = memRdata;
      WSRC_IMM: regNext = ir2;
      WSRC_ADD: regNext = rnVal + rmVal;
      default:  regNext = rnVal - rmVal;
    endcase
  end

  always_comb begin
    unique case (ctl.addrSel)
      ADDR_IMM: memAddr = ir2;
      ADDR_RN:  memAddr = rnVal;
      default:  memAddr = pc;
    endcase
  end

  assign memWdata = ctl.wdataRm ? rmVal : rnVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc  <= '0;
      ir1 <= '0;
      ir2 <= '0;
    end else begin
      if (ctl.loadIr1) ir1 <= memRdata;
      if (ctl.loadIr2) ir2 <= memRdata;
      if (ctl.pcZero)        pc <= '0;
      else if (ctl.pcInc)    pc <= pc + 1'b1;
      else if (ctl.pcBranch) pc <= pc + ir2;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regs[g] <= '0;
      else if (ctl.regWe && rnIdx == IDX_W'(g))
        regs[g] <= regNext;
    end
  end

  // R6: the program counter moves only on an increment, clear or branch strobe
  a_r6_pc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.pcZero || ctl.pcInc || ctl.pcBranch) |=> $stable(pc));

  // R1: a clear strobe leaves the program counter at zero
  a_r1_pc_cleared: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pcZero |=> pc == '0);
endmodule

// File: rtl/twobyte_cpu_ctl.sv
module twobyte_cpu_ctl
  import twobyte_cpu_pkg::*;
#(
  parameter int NUM_REGS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [BYTE_W-1:0] ir1,
  input  logic [BYTE_W-1:0] ir2,
  input  logic              rnZero,
  output strobes_t          ctl,
  output logic              busy,
  output logic              halted
);
  state_e state, stateNext;
  logic [NIB_W-1:0] opcode, rnNum, rmNum;
  logic usesRm, opKnown, legal;

  assign opcode = ir1[BYTE_W-1 -: NIB_W];
  assign rnNum  = ir1[NIB_W-1:0];
  assign rmNum  = ir2[BYTE_W-1 -: NIB_W];
  assign usesRm = opcode inside {OP_STI, OP_ADD, OP_SUB};
  assign opKnown = opcode inside {OP_LDD, OP_STD, OP_STI, OP_LDI, OP_ADD, OP_SUB, OP_JZ};
  assign legal  = opKnown && (32'(rnNum) < NUM_REGS)
                  && (!usesRm || (32'(rmNum) < NUM_REGS));

  always_comb begin
    ctl = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE, ST_HALT: begin
        if (start) begin
          ctl.pcZero = 1'b1;
          stateNext = ST_FETCH1;
        end
      end
      ST_FETCH1: begin
        ctl.loadIr1 = 1'b1;
        ctl.pcInc   = 1'b1;
        stateNext   = ST_FETCH2;
      end
      ST_FETCH2: begin
        ctl.loadIr2 = 1'b1;
        ctl.pcInc   = 1'b1;
        stateNext   = ST_EXEC;
      end
      default: begin
        if (!legal) begin
          stateNext = ST_HALT;
        end else begin
          stateNext = ST_FETCH1;
          unique case (opcode)
            OP_LDD: begin ctl.addrSel = ADDR_IMM; ctl.regSrc = WSRC_MEM; ctl.regWe = 1'b1; end
            OP_STD: begin ctl.addrSel = ADDR_IMM; ctl.memWe = 1'b1; end
            OP_STI: begin ctl.addrSel = ADDR_RN; ctl.wdataRm = 1'b1; ctl.memWe = 1'b1; end
            OP_LDI: begin ctl.regSrc = WSRC_IMM; ctl.regWe = 1'b1; end
            OP_ADD: begin ctl.regSrc = WSRC_ADD; ctl.regWe = 1'b1; end
            OP_SUB: begin ctl.regSrc = WSRC_SUB; ctl.regWe = 1'b1; end
            default: ctl.pcBranch = rnZero;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy   = state inside {ST_FETCH1, ST_FETCH2, ST_EXEC};
  assign halted = (state == ST_HALT);

  // R8: the two fetch cycles and the execute cycle follow in a fixed order
  a_r8_second_fetch: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_FETCH1 |=> state == ST_FETCH2);
  a_r8_exec_follows: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_FETCH2 |=> state == ST_EXEC);

  // R7: a stopped processor stays stopped until started again
  a_r7_halt_holds: assert property (@(posedge clk) disable iff (!rstN)
    halted && !start |=> halted && !busy);

  // R3: memory is never written during a fetch cycle
  a_r3_no_fetch_write: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FETCH1 || state == ST_FETCH2) |-> !ctl.memWe);
endmodule

// File: rtl/twobyte_cpu.sv
module twobyte_cpu
  import twobyte_cpu_pkg::*;
#(
  parameter int NUM_REGS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic              halted,
  input  logic              tstWe,
  input  logic [BYTE_W-1:0] tstAddr,
  input  logic [BYTE_W-1:0] tstWdata,
  output logic [BYTE_W-1:0] tstRdata
);
  strobes_t          ctl;
  logic [BYTE_W-1:0] ir1, ir2, memAddr, memWdata, memRdata;
  logic              rnZero;

  twobyte_cpu_ctl #(.NUM_REGS(NUM_REGS)) ctl_i (
    .clk, .rstN, .start, .ir1, .ir2, .rnZero, .ctl, .busy, .halted
  );

  twobyte_cpu_dp #(.NUM_REGS(NUM_REGS)) dp_i (
    .clk, .rstN, .ctl, .memRdata, .memAddr, .memWdata, .ir1, .ir2, .rnZero
  );

  twobyte_cpu_mem mem_i (
    .clk, .busy, .we(ctl.memWe), .addr(memAddr), .wdata(memWdata),
    .rdata(memRdata), .tstWe, .tstAddr, .tstWdata, .tstRdata
  );
endmodule

// File: tb/twobyte_cpu_tb.sv
`timescale 1ns/1ps
module twobyte_cpu_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       busy, halted;
  logic       tstWe = 1'b0;
  logic [7:0] tstAddr = '0;
  logic [7:0] tstWdata = '0;
  logic [7:0] tstRdata;

  int checks = 0;
  int errors = 0;
  logic [7:0] prog [64];
  int progLen = 0;

  always #4 clk = ~clk;

  twobyte_cpu dut_i (
    .clk, .rstN, .start, .busy, .halted,
    .tstWe, .tstAddr, .tstWdata, .tstRdata
  );

  function automatic logic [7:0] expAlu(logic [7:0] a, logic [7:0] b, bit isSub);
    int r;
    r = isSub ? (int'(a) - int'(b)) : (int'(a) + int'(b));
    return 8'(((r % 256) + 256) % 256);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b1, input logic [7:0] b2);
    prog[progLen] = b1;
    prog[progLen+1] = b2;
    progLen += 2;
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    tstWe = 1'b1; tstAddr = a; tstWdata = d;
    @(negedge clk);
    tstWe = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    tstAddr = a;
    #1;
    d = tstRdata;
  endtask

  task automatic loadProg();
    for (int i = 0; i < progLen; i++) poke(8'(i), prog[i]);
    progLen = 0;
  endtask

  task automatic runProg(output int cyc);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!halted && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    chk(halted, "R1 run did not stop", int'(halted), 1);
  endtask

  task automatic aluTrial(input logic [7:0] a, input logic [7:0] b, input bit isSub,
                          input int n, input int m);
    int cyc;
    logic [7:0] got, exp;
    poke(8'h80, 8'h00);
    put({4'h3, 4'(n)}, a);
    put({4'h3, 4'(m)}, b);
    put({isSub ? 4'h5 : 4'h4, 4'(n)}, {4'(m), 4'hA}); // R2: low nibble of byte two ignored
    put({4'h1, 4'(n)}, 8'h80);
    put(8'hF0, 8'h00);
    loadProg();
    runProg(cyc);
    peek(8'h80, got);
    exp = expAlu(a, b, isSub);
    chk(got == exp, "R5 add/sub result", got, exp);
    chk(cyc == 15, "R8 cycles for four instructions", cyc, 15);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc;
    logic [7:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !halted, "R1 reset state", {busy, halted}, 0);

    // R9: idle test write lands and reads back
    poke(8'h90, 8'h11);
    peek(8'h90, v);
    chk(v == 8'h11, "R9 idle test write", v, 8'h11);

    // R10 / R6: summing loop with a forward exit and an unconditional back branch
    poke(8'h80, 8'h00);
    put(8'h30, 8'h00); put(8'h31, 8'h0A); put(8'h32, 8'h01); put(8'h33, 8'h00);
    put(8'h81, 8'h06); put(8'h40, 8'h10); put(8'h51, 8'h20); put(8'h83, 8'hF8);
    put(8'h10, 8'h80); put(8'hF0, 8'h00);
    loadProg();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy, "R1 busy after start", int'(busy), 1);
    repeat (10) @(negedge clk);
    tstWe = 1'b1; tstAddr = 8'h90; tstWdata = 8'hAA; // collides with running program
    @(negedge clk); tstWe = 1'b0;
    start = 1'b1; // R1: start while running is ignored
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!halted && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(halted, "R7 loop ends on illegal code", int'(halted), 1);
    peek(8'h80, v);
    chk(v == 8'd55, "R10 sum of 10..1", v, 55);
    peek(8'h90, v);
    chk(v == 8'h11, "R9 test write ignored while busy", v, 8'h11);

    // R3: direct load and store
    poke(8'h70, 8'h5C); poke(8'h81, 8'h00);
    put(8'h02, 8'h70); put(8'h12, 8'h81); put(8'hF0, 8'h00);
    loadProg(); runProg(cyc);
    peek(8'h81, v);
    chk(v == 8'h5C, "R3 direct load then store", v, 8'h5C);
    chk(cyc == 9, "R8 cycles", cyc, 9);

    // R4: pointer store, low nibble of byte two ignored
    poke(8'h84, 8'h00);
    put(8'h32, 8'h84); put(8'h33, 8'hC7); put(8'h22, 8'h3F); put(8'hF0, 8'h00);
    loadProg(); runProg(cyc);
    peek(8'h84, v);
    chk(v == 8'hC7, "R4 store through pointer", v, 8'hC7);

    // R6: branch not taken, then taken
    put(8'h30, 8'h11); put(8'h31, 8'h05); put(8'h81, 8'h02); put(8'h30, 8'h99);
    put(8'h10, 8'h82); put(8'hF0, 8'h00);
    loadProg(); runProg(cyc);
    peek(8'h82, v);
    chk(v == 8'h99, "R6 branch not taken", v, 8'h99);
    poke(8'h03, 8'h00); // make R1 zero
    runProg(cyc);
    peek(8'h82, v);
    chk(v == 8'h11, "R6 branch taken skips one instruction", v, 8'h11);
    chk(cyc == 15, "R8 cycles with taken branch", cyc, 15);

    // R7: out-of-range Rn
    poke(8'h83, 8'hEE);
    put(8'h30, 8'h11); put(8'h34, 8'h22); put(8'h10, 8'h83); put(8'hF0, 8'h00);
    loadProg(); runProg(cyc);
    peek(8'h83, v);
    chk(v == 8'hEE, "R7 no store after bad Rn", v, 8'hEE);
    chk(cyc == 6, "R7 stops after second instruction", cyc, 6);
    chk(!busy, "R7 busy low when halted", int'(busy), 0);

    // R7: out-of-range Rm on add, then unknown code
    put(8'h30, 8'h42); put(8'h40, 8'h50); put(8'h10, 8'h83); put(8'hF0, 8'h00);
    loadProg(); runProg(cyc);
    peek(8'h83, v);
    chk(v == 8'hEE, "R7 no store after bad Rm", v, 8'hEE);
    put(8'h30, 8'h42); put(8'h60, 8'h00); put(8'h10, 8'h83); put(8'hF0, 8'h00);
    loadProg(); runProg(cyc);
    peek(8'h83, v);
    chk(v == 8'hEE, "R7 no store after unknown code", v, 8'hEE);
    chk(cyc == 6, "R7 unknown code stops", cyc, 6);

    // R5 wrap corners
    aluTrial(8'd200, 8'd100, 1'b0, 0, 1);
    aluTrial(8'd5, 8'd10, 1'b1, 2, 3);
    aluTrial(8'd0, 8'd0, 1'b1, 3, 0);

    // R2 / R5: random operands and register pairs
    for (int t = 0; t < 12; t++) begin
      int n, m;
      n = int'($urandom % 4);
      m = (n + 1 + int'($urandom % 3)) % 4;
      aluTrial(8'($urandom), 8'($urandom), 1'($urandom), n, m);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule